// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Generator

This block builds the status byte that a host processor reads from a flash macro while an embedded program or erase is running, and it drives a ready/busy pin. A command decoder upstream pulses one of three start inputs: program, sector erase or bulk erase. It presents these pulses when the last write of the command sequence is accepted, so the polling bits are valid from the cycle that follows. With the pulse come the bit 7 of the byte being programmed and a flag that says whether the target (or every sector chosen for erase) is write protected. A behavioural operation timer later reports completion or failure.

While an operation is active, the read path returns a synthesized status byte instead of array data. Bit 7 is the data-polling bit, bit 6 is a toggle bit, bit 5 is a sticky error flag and bit 3 marks the sector-erase acceptance window. Bits 4, 2, 1 and 0 read as 0. When nothing is active, the array data passes through unchanged. The read path is a single-cycle strobe with a combinational result: there is no back-pressure, and each cycle with `rd_en` high counts as one read.

Top module: `pe_status_gen`

## Requirements
- R1: With no operation active (after reset, after a completed operation, or after a clear), `rd_data` equals `array_data` and `ready` is 1.
- R2: A program start with `tgt_protected`=0 makes `ready` 0 from the next cycle. Bit 7 of the status reads as the inverse of `prog_bit7` and bit 3 reads 0. After `op_done` the array data is passed through again.
- R3: A sector or bulk erase start with `tgt_protected`=0 makes `ready` 0. Bit 7 reads 0 until `op_done`, after which the array data is passed through.
- R4: Bit 6 reads 0 on the first read after any accepted start. It inverts after every cycle in which `rd_en` and `sect_sel` are both 1 while a status byte is shown, and it holds when `sect_sel` is 0.
- R5: `op_fail` during a program or erase sets bit 5 to 1 and ends the busy state (`ready`=1). The status byte stays on the read path, ignoring `op_done`, until `err_clear` or `rst_n` low returns the block to pass-through.
- R6: After an accepted sector-erase start, bit 3 reads 0 for exactly `WIN_CYC` cycles and then 1. After a bulk-erase start, bit 3 reads 1.
- R7: A further sector-erase pulse during an erase closes the window at once: bit 3 reads 1 from the next cycle. The erase continues.
- R8: A program start with `tgt_protected`=1 is ignored. `ready` stays 1 and the array data keeps passing through.
- R9: An erase start with `tgt_protected`=1 gives a pseudo-busy period of exactly `PSEUDO_CYC` cycles. During this period `ready` is 0, bit 7 is 0, bit 6 toggles and `op_done` is ignored. Pass-through then returns.
- R10: In the status byte, bits 4, 2, 1 and 0 always read 0.
- R11: Start pulses received while a status byte is shown are ignored. If several start pulses arrive together in the idle state, program wins over sector erase, and sector erase wins over bulk erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Program start pulse |
| start_sect_erase | input | 1 | Sector-erase start pulse |
| start_bulk_erase | input | 1 | Bulk-erase start pulse |
| tgt_protected | input | 1 | Target (or all sectors chosen for erase) is write protected |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed, sampled with the start |
| op_done | input | 1 | Operation timer reports completion |
| op_fail | input | 1 | Operation timer reports failure (timeout, 0-to-1 attempt) |
| err_clear | input | 1 | Reset command that clears the error state |
| rd_en | input | 1 | Read strobe on the status path |
| sect_sel | input | 1 | Sector select of the read is active |
| array_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data: status byte or array data |
| ready | output | 1 | 1 = ready, 0 = program or erase in progress |

## Verification
The bench builds the block with `WIN_CYC`=6 and `PSEUDO_CYC`=10, in place of the microsecond-scale defaults. With these values, both timed windows can be walked cycle by cycle, so the exact cycle where bit 3 turns to 1 and the exact cycle where the pseudo-busy period ends are both checked. Because the erase window is shorter than the pseudo-busy period, the two counters expire at different cycles, so an error that mixes them up shows. The same small values also make room to inject `op_done` in the middle of the protected-erase period.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_ERASE  = 3'd2,
    ST_PSEUDO = 3'd3,
    ST_FAIL   = 3'd4
  } op_state_e;

  // status byte layout, decoded by host software
  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_ERR  = 5;
  localparam int unsigned BIT_WIN  = 3;

endpackage

// File: rtl/pe_win_timer.sv
module pe_win_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic running,
  output logic expire
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign running = run_q;
  assign expire  = run_q && (cnt_q == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (abort || expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: a running window only stops by expiry or abort
  p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && !abort && !expire) |=> run_q);

endmodule

// File: rtl/pe_op_ctrl.sv
module pe_op_ctrl
  import pe_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_prog,
  input  logic      start_serase,
  input  logic      start_berase,
  input  logic      tgt_prot,
  input  logic      prog_d7,
  input  logic      op_done,
  input  logic      op_fail,
  input  logic      err_clr,
  input  logic      pseudo_exp,
  output op_state_e state,
  output logic      is_prog,
  output logic      d7_q,
  output logic      restart,
  output logic      pseudo_start,
  output logic      win_start,
  output logic      win_abort
);
  op_state_e st_q, st_d;
  logic      prog_q, bit7_q;
  logic      go_p, go_se, go_be, idle;

  assign idle  = (st_q == ST_IDLE);
  assign go_p  = start_prog;
  assign go_se = !start_prog && start_serase;
  assign go_be = !start_prog && !start_serase && start_berase;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go_p && !tgt_prot)                st_d = ST_PROG;
        else if ((go_se || go_be) && !tgt_prot) st_d = ST_ERASE;
        else if ((go_se || go_be) && tgt_prot)  st_d = ST_PSEUDO;
      end
      ST_PROG, ST_ERASE: begin
        if (op_fail)      st_d = ST_FAIL;
        else if (op_done) st_d = ST_IDLE;
      end
      ST_PSEUDO: if (pseudo_exp) st_d = ST_IDLE;
      ST_FAIL:   if (err_clr)    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign restart      = idle && (st_d != ST_IDLE);
  assign pseudo_start = idle && (st_d == ST_PSEUDO);
  assign win_start    = idle && go_se;
  assign win_abort    = (!idle && start_serase) ||
                        (((st_q == ST_ERASE) || (st_q == ST_PSEUDO)) && (st_d != st_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b0;
      bit7_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (restart) begin
        prog_q <= (st_d == ST_PROG);
        bit7_q <= prog_d7;
      end
    end
  end

  assign state   = st_q;
  assign is_prog = prog_q;
  assign d7_q    = bit7_q;

  // R8: protected program leaves the block idle
  p_prot_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_prog && tgt_prot) |=> (st_q == ST_IDLE));
  // R11: a running program ignores new starts
  p_hold_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROG && !op_done && !op_fail) |=> (st_q == ST_PROG));
  // R5: error state holds until the clear command
  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && !err_clr) |=> (st_q == ST_FAIL));
  // R9: pseudo-busy ignores the operation timer
  p_pseudo_deaf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PSEUDO && !pseudo_exp) |=> (st_q == ST_PSEUDO));

endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux
  import pe_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_state_e         state,
  input  logic              is_prog,
  input  logic              d7_q,
  input  logic              win_run,
  input  logic              restart,
  input  logic              rd_en,
  input  logic              sect_sel,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  logic tog_q;
  logic active;

  assign active = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tog_q <= 1'b0;
    else if (restart)                    tog_q <= 1'b0;
    else if (active && rd_en && sect_sel) tog_q <= ~tog_q;
  end

  always_comb begin
    if (!active) begin
      rd_data = array_data;
    end else begin
      rd_data           = '0;
      rd_data[BIT_POLL] = is_prog ? ~d7_q : 1'b0;
      rd_data[BIT_TOG]  = tog_q;
      rd_data[BIT_ERR]  = (state == ST_FAIL);
      rd_data[BIT_WIN]  = is_prog ? 1'b0 : ~win_run;
    end
  end

  assign ready = !((state == ST_PROG) || (state == ST_ERASE) || (state == ST_PSEUDO));

  // R4: each selected read during a status phase flips the toggle bit
  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_en && sect_sel) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WIN_CYC    = 12500,
  parameter int unsigned PSEUDO_CYC = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_sect_erase,
  input  logic              start_bulk_erase,
  input  logic              tgt_protected,
  input  logic              prog_bit7,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              err_clear,
  input  logic              rd_en,
  input  logic              sect_sel,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  op_state_e state;
  logic is_prog, d7_q, restart;
  logic pseudo_start, pseudo_exp, pseudo_run;
  logic win_start, win_abort, win_run, win_exp;

  pe_op_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_prog   (start_prog),
    .start_serase (start_sect_erase),
    .start_berase (start_bulk_erase),
    .tgt_prot     (tgt_protected),
    .prog_d7      (prog_bit7),
    .op_done      (op_done),
    .op_fail      (op_fail),
    .err_clr      (err_clear),
    .pseudo_exp   (pseudo_exp),
    .state        (state),
    .is_prog      (is_prog),
    .d7_q         (d7_q),
    .restart      (restart),
    .pseudo_start (pseudo_start),
    .win_start    (win_start),
    .win_abort    (win_abort)
  );

  pe_win_timer #(.LEN(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (win_start),
    .abort   (win_abort),
    .running (win_run),
    .expire  (win_exp)
  );

  pe_win_timer #(.LEN(PSEUDO_CYC)) u_pseudo (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pseudo_start),
    .abort   (1'b0),
    .running (pseudo_run),
    .expire  (pseudo_exp)
  );

  pe_status_mux #(.DATA_W(DATA_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .is_prog    (is_prog),
    .d7_q       (d7_q),
    .win_run    (win_run),
    .restart    (restart),
    .rd_en      (rd_en),
    .sect_sel   (sect_sel),
    .array_data (array_data),
    .rd_data    (rd_data),
    .ready      (ready)
  );

  // R7: a second sector-erase command during erase closes the window
  p_win_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && start_sect_erase && win_run) |=> !win_run);
  // R9: the pseudo-busy timer runs only while pseudo-busy
  p_pseudo_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo_run |-> !ready);

endmodule

// File: tb/tb_pe_status_gen.sv
module tb_pe_status_gen;
  localparam int WIN = 6;
  localparam int PSE = 10;
  localparam int NV  = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_p = 0, s_se = 0, s_be = 0, prot = 0, d7 = 0, done = 0, fail = 0, clr = 0, rd = 0, sel = 0;
  logic [7:0] arr = 8'h00;
  logic [7:0] rdata;
  logic rdy;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pe_status_gen #(.DATA_W(8), .WIN_CYC(WIN), .PSEUDO_CYC(PSE)) dut (
    .clk(clk), .rst_n(rst_n), .start_prog(s_p), .start_sect_erase(s_se),
    .start_bulk_erase(s_be), .tgt_protected(prot), .prog_bit7(d7),
    .op_done(done), .op_fail(fail), .err_clear(clr), .rd_en(rd),
    .sect_sel(sel), .array_data(arr), .rd_data(rdata), .ready(rdy)
  );

  // cmd: 0 none, 1 program, 2 sector erase, 3 bulk erase
  function automatic logic [29:0] v(input int cmd, input bit pr, input bit b7, input bit dn,
                                    input bit fl, input bit cl, input bit r, input bit s,
                                    input logic [7:0] a, input logic [7:0] e, input bit ry,
                                    input int rq);
    return {2'(cmd), pr, b7, dn, fl, cl, r, s, a, e, ry, 4'(rq)};
  endfunction

  localparam logic [29:0] VEC [NV] = '{
    v(0,0,0,0,0,0,0,0,8'hA5,8'hA5,1,1),  // R1 pass-through
    v(0,0,0,0,0,0,0,0,8'h3C,8'h3C,1,1),  // R1
    v(1,0,1,0,0,0,0,0,8'h3C,8'h3C,1,2),  // R2 program start
    v(0,0,0,0,0,0,1,1,8'h3C,8'h00,0,2),  // R2 bit7 = ~1
    v(0,0,0,0,0,0,1,1,8'h3C,8'h40,0,4),  // R4 toggled
    v(0,0,0,0,0,0,1,0,8'h3C,8'h00,0,4),  // R4 no sel, no flip
    v(0,0,0,0,0,0,0,0,8'h3C,8'h00,0,2),  // R2
    v(2,0,0,0,0,0,0,0,8'h3C,8'h00,0,11), // R11 ignored start
    v(0,0,0,1,0,0,0,0,8'hFF,8'h00,0,2),  // R2 done
    v(0,0,0,0,0,0,0,0,8'hFF,8'hFF,1,2),  // R2 data back
    v(1,0,0,0,0,0,0,0,8'h11,8'h11,1,2),  // R2 program 0
    v(0,0,0,0,0,0,0,0,8'h11,8'h80,0,2),  // R2 bit7 = ~0
    v(0,0,0,0,1,0,0,0,8'h11,8'h80,0,5),  // R5 fail
    v(0,0,0,0,0,0,0,0,8'h11,8'hA0,1,5),  // R5 error bit
    v(0,0,0,0,0,0,1,1,8'h11,8'hA0,1,4),  // R4 toggles in error
    v(0,0,0,1,0,0,0,0,8'h11,8'hE0,1,5),  // R5 done ignored
    v(3,0,0,0,0,0,0,0,8'h11,8'hE0,1,11), // R11
    v(0,0,0,0,0,1,0,0,8'h11,8'hE0,1,5),  // R5 clear
    v(0,0,0,0,0,0,0,0,8'h5A,8'h5A,1,5),  // R5 pass-through
    v(3,0,0,0,0,0,0,0,8'h5A,8'h5A,1,3),  // R3 bulk start
    v(0,0,0,0,0,0,0,0,8'h5A,8'h08,0,10), // R10 R6 bulk bit3=1
    v(0,0,0,0,0,0,1,1,8'h5A,8'h08,0,4),  // R4
    v(0,0,0,0,0,0,0,0,8'h5A,8'h48,0,4),  // R4
    v(0,0,0,1,0,0,0,0,8'h5A,8'h48,0,3),  // R3 done
    v(0,0,0,0,0,0,0,0,8'hC3,8'hC3,1,3),  // R3
    v(1,1,1,0,0,0,0,0,8'hC3,8'hC3,1,8),  // R8 protected program
    v(0,0,0,0,0,0,0,0,8'hC3,8'hC3,1,8)   // R8
  };

  task automatic chk(input string req, input logic [7:0] ed, input bit er);
    n_run++;
    if (rdata !== ed || rdy !== er) begin
      n_fail++;
      $display("FAIL %s: rd_data=%02h ready=%0b expected rd_data=%02h ready=%0b", req, rdata, rdy, ed, er);
    end
  endtask

  task automatic idle_in();
    s_p = 0; s_se = 0; s_be = 0; prot = 0; d7 = 0; done = 0; fail = 0; clr = 0; rd = 0; sel = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    idle_in();
    arr = 8'h96;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset", 8'h96, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      {s_p, s_se, s_be} = 3'b000;
      case (VEC[i][29:28])
        2'd1: s_p = 1;
        2'd2: s_se = 1;
        2'd3: s_be = 1;
        default: ;
      endcase
      {prot, d7, done, fail, clr, rd, sel} = VEC[i][27:21];
      arr = VEC[i][20:13];
      #1;
      chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][12:5], VEC[i][4]);
      tick();
    end

    // R6: sector-erase window length
    arr = 8'h77; s_se = 1; #1;
    chk("R6 before start", 8'h77, 1'b1);
    tick();
    for (int i = 0; i <= WIN; i++) begin
      #1;
      chk("R6 R10 window", (i >= WIN) ? 8'h08 : 8'h00, 1'b0);
      tick();
    end
    done = 1; tick(); #1;
    chk("R6 done", 8'h77, 1'b1);

    // R7: second sector erase closes window early
    s_se = 1; tick(); #1;
    chk("R7 open", 8'h00, 1'b0);
    s_se = 1; tick(); #1;
    chk("R7 closed", 8'h08, 1'b0);
    done = 1; tick(); #1;
    chk("R7 done", 8'h77, 1'b1);

    // R9: protected erase gives pseudo-busy
    s_be = 1; prot = 1; tick();
    for (int i = 0; i <= PSE; i++) begin
      rd = 1; sel = 1; done = (i == 3);
      #1;
      if (i < PSE) chk("R9 pseudo busy", (i % 2 == 1) ? 8'h48 : 8'h08, 1'b0);
      else         chk("R9 pseudo end", 8'h77, 1'b1);
      tick();
    end

    // R5: reset also clears the error state
    s_p = 1; d7 = 1; tick();
    fail = 1; tick(); #1;
    chk("R5 error set", 8'h20, 1'b1);
    rst_n = 0; #1;
    chk("R5 reset clears", 8'h77, 1'b1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after reset", 8'h77, 1'b1);

    finish_run();
  end
endmodule